// File: doc/BRIEF.md
# Slot-Based Flexible Power Sequencer

This block orders the switching of a group of power rails, GPIO enables and a clock enable. Three shared master timers each watch an enable level. That level is taken from one of two hardware pins, from a software bit, or from nothing. Whenever the level changes in either direction, the timer broadcasts eight numbered slot events. The events are spaced by a period chosen from a doubling series of microsecond intervals. A single one-microsecond tick input paces every timer.

Each slave output is tied either to one timer or to a software bit of its own. A slave tied to a timer switches on when a rising sequence reaches its own power-up slot. It acts when a falling sequence reaches its own power-down slot. What it does then depends on one global setting: it turns off, it enters a low-power indication, or it keeps its state.

A separate option maps a group of power-good inputs onto a reset/GPIO output. All settings are loaded through a plain address/data write port.

Top module: `fps_seq`

## Requirements
- R1: Timer k (k = 0..2) is configured at address k. Bits [1:0] select its level: 0 is hw_en_i[0], 1 is hw_en_i[1], 2 is data bit [5] of the same word, and 3 is constant low. After a write changes a software-selected level, the timer registers its slot-0 event on the next clock.
- R2: Both hardware enable pins pass through a two-flop synchroniser. A pin change captured at clock edge H shows as a slot-0 event (busy set) at edge H+2 and not at edge H+1.
- R3: Every rise or fall of a timer's level produces eight events, for slots 0 through 7, in increasing order. The timer's slot index changes only with an event. Busy stays high from the slot-0 event until one full period after the slot-7 event.
- R4: The slot period in ticks is 40·2^code, where code is bits [4:2] of the timer word. With code 1, consecutive events are 80 ticks apart.
- R5: Slave i is configured at address 4+i. Bits [1:0] hold the source (0 to 2 select a timer, 3 selects software), bits [4:2] the up slot, bits [7:5] the down slot, and bit [8] the software bit. On a rising sequence, the slave's enable goes high one clock after the event for its up slot.
- R6: On a falling sequence, at the slave's down slot, the global mode (address 3, bits [1:0]) decides the action. Mode 1 clears the enable. Mode 2 raises the low-power flag and keeps the enable. Modes 0 and 3 leave the slave unchanged. The low-power flag is never high while the enable is low.
- R7: A slave whose source is software copies its software bit one clock after its configuration register holds it, with the low-power flag low.
- R8: Address 3 bit [2] turns on power-good mapping, and bits [15:8] mask which pok_i inputs take part. When mapping is on, rst_io_o is high one clock after every masked input is high, and low one clock after any masked input drops. When mapping is off, rst_io_o is high.
- R9: A new level edge during a running sequence restarts that timer at slot 0 in the new direction. Slaves that already acted keep their state, and slots not yet reached in the old direction never fire.
- R10: After reset, all slave enables, low-power flags, busy flags and slot indices are 0, and rst_io_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-microsecond timing strobe |
| hw_en_i | input | 2 | Hardware enable pins, asynchronous |
| wr_en_i | input | 1 | Configuration write strobe |
| wr_addr_i | input | ADDR_W | Configuration address |
| wr_data_i | input | 16 | Configuration write data |
| pok_i | input | N_SLV | Power-good inputs, one per slave |
| slv_en_o | output | N_SLV | Slave enables |
| slv_lp_o | output | N_SLV | Slave low-power indications |
| rst_io_o | output | 1 | Power-good mapped reset/GPIO output |
| tmr_busy_o | output | 3 | Timer sequence running flags |
| tmr_slot_o | output | 9 | Current slot index of each timer, 3 bits each |

## Verification
Two functions can fall in the same clock: a new level edge arriving while a timer is still counting, and that timer's own slot advance. Restart must win over the advance. The bench provokes this by reversing a software-driven timer about 60 ticks into a rising sequence, after slot 1 has fired. It then judges the outcome at the ports. Slot 0 must reappear in the falling direction. The slave whose up slot was 3 must never switch on. The slave already on must switch off exactly 280 ticks after the restart. Busy must hold until 320 ticks after the restart rather than 320 ticks after the original start.

// File: rtl/fps_pkg.sv
package fps_pkg;
  localparam int N_TMR = 3;
  localparam int SLOT_W = 3;

  typedef enum logic [1:0] {
    TSRC_HW0 = 2'd0,
    TSRC_HW1 = 2'd1,
    TSRC_SW  = 2'd2,
    TSRC_OFF = 2'd3
  } tsrc_e;

  typedef struct packed {
    logic              sw;
    logic [2:0]        code;
    tsrc_e             src;
  } tmr_cfg_t;

  typedef struct packed {
    logic              sw;
    logic [SLOT_W-1:0] dn;
    logic [SLOT_W-1:0] up;
    logic [1:0]        src;
  } slv_cfg_t;

  localparam logic [1:0] SLV_SRC_SW = 2'd3;
  localparam logic [1:0] MODE_SLEEP = 2'd1;
  localparam logic [1:0] MODE_LP    = 2'd2;
endpackage

// File: rtl/fps_sync.sv
module fps_sync #(
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      q_o    <= '0;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/fps_cfg.sv
module fps_cfg import fps_pkg::*; #(
  parameter int N_SLV  = 6,
  parameter int ADDR_W = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  logic [ADDR_W-1:0]      wr_addr_i,
  input  logic [15:0]            wr_data_i,
  output tmr_cfg_t [N_TMR-1:0]   tmr_o,
  output slv_cfg_t [N_SLV-1:0]   slv_o,
  output logic [1:0]             mode_o,
  output logic                   pok_en_o,
  output logic [N_SLV-1:0]       pok_mask_o
);
  localparam int ADDR_GLB  = N_TMR;
  localparam int ADDR_SLV0 = N_TMR + 1;

  logic unused_data;
  assign unused_data = ^wr_data_i;

  for (genvar k = 0; k < N_TMR; k++) begin : g_tmr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) tmr_o[k] <= '0;
      else if (wr_en_i && wr_addr_i == ADDR_W'(k)) tmr_o[k] <= tmr_cfg_t'(wr_data_i[5:0]);
    end
  end

  for (genvar i = 0; i < N_SLV; i++) begin : g_slv
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) slv_o[i] <= '0;
      else if (wr_en_i && wr_addr_i == ADDR_W'(ADDR_SLV0 + i)) slv_o[i] <= slv_cfg_t'(wr_data_i[8:0]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o     <= '0;
      pok_en_o   <= 1'b0;
      pok_mask_o <= '0;
    end else if (wr_en_i && wr_addr_i == ADDR_W'(ADDR_GLB)) begin
      mode_o     <= wr_data_i[1:0];
      pok_en_o   <= wr_data_i[2];
      pok_mask_o <= wr_data_i[8 +: N_SLV];
    end
  end
endmodule

// File: rtl/fps_timer.sv
module fps_timer import fps_pkg::*; #(
  parameter int BASE_US = 40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [1:0]        hw_i,
  input  tmr_cfg_t          cfg_i,
  output logic              evt_o,
  output logic              up_o,
  output logic              busy_o,
  output logic [SLOT_W-1:0] slot_o
);
  localparam int CNT_W = $clog2(BASE_US * 128);

  logic             lvl, lvl_q, edge_det;
  logic [CNT_W-1:0] cnt_q, lim;

  always_comb begin
    case (cfg_i.src)
      TSRC_HW0: lvl = hw_i[0];
      TSRC_HW1: lvl = hw_i[1];
      TSRC_SW:  lvl = cfg_i.sw;
      default:  lvl = 1'b0;
    endcase
  end

  assign edge_det = lvl ^ lvl_q;
  assign lim      = CNT_W'((BASE_US << cfg_i.code) - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q  <= 1'b0;
      evt_o  <= 1'b0;
      up_o   <= 1'b0;
      busy_o <= 1'b0;
      slot_o <= '0;
      cnt_q  <= '0;
    end else begin
      lvl_q <= lvl;
      evt_o <= 1'b0;
      if (edge_det) begin
        // restart from slot 0 in the new direction
        busy_o <= 1'b1;
        up_o   <= lvl;
        slot_o <= '0;
        cnt_q  <= '0;
        evt_o  <= 1'b1;
      end else if (busy_o && tick_i) begin
        if (cnt_q == lim) begin
          cnt_q <= '0;
          if (slot_o == SLOT_W'(7)) begin
            busy_o <= 1'b0;
          end else begin
            slot_o <= slot_o + 1'b1;
            evt_o  <= 1'b1;
          end
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  // R3
  evt_in_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |-> busy_o);
  // R3
  slot_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_o && slot_o != '0) |-> slot_o == $past(slot_o) + 1'b1);
  // R3
  slot_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !evt_o |-> $stable(slot_o));
  // R9
  restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_det |=> (evt_o && slot_o == '0 && up_o == $past(lvl)));
endmodule

// File: rtl/fps_slave.sv
module fps_slave import fps_pkg::*; (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [N_TMR-1:0]             evt_i,
  input  logic [N_TMR-1:0]             up_i,
  input  logic [N_TMR-1:0][SLOT_W-1:0] slot_i,
  input  slv_cfg_t                     cfg_i,
  input  logic [1:0]                   mode_i,
  output logic                         en_o,
  output logic                         lp_o
);
  logic              evt_s, up_s;
  logic [SLOT_W-1:0] slot_s;

  always_comb begin
    evt_s  = 1'b0;
    up_s   = 1'b0;
    slot_s = '0;
    for (int t = 0; t < N_TMR; t++) begin
      if (cfg_i.src == 2'(t)) begin
        evt_s  = evt_i[t];
        up_s   = up_i[t];
        slot_s = slot_i[t];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o <= 1'b0;
      lp_o <= 1'b0;
    end else if (cfg_i.src == SLV_SRC_SW) begin
      en_o <= cfg_i.sw;
      lp_o <= 1'b0;
    end else if (evt_s) begin
      if (up_s && slot_s == cfg_i.up) begin
        en_o <= 1'b1;
        lp_o <= 1'b0;
      end else if (!up_s && slot_s == cfg_i.dn) begin
        if (mode_i == MODE_SLEEP) begin
          en_o <= 1'b0;
          lp_o <= 1'b0;
        end else if (mode_i == MODE_LP) begin
          lp_o <= en_o;
        end
      end
    end
  end

  // R6
  lp_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lp_o |-> en_o);
  // R7
  sw_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i.src == SLV_SRC_SW) |=> (en_o == $past(cfg_i.sw) && !lp_o));
endmodule

// File: rtl/fps_seq.sv
module fps_seq import fps_pkg::*; #(
  parameter int N_SLV   = 6,
  parameter int ADDR_W  = 4,
  parameter int BASE_US = 40
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    tick_i,
  input  logic [1:0]              hw_en_i,
  input  logic                    wr_en_i,
  input  logic [ADDR_W-1:0]       wr_addr_i,
  input  logic [15:0]             wr_data_i,
  input  logic [N_SLV-1:0]        pok_i,
  output logic [N_SLV-1:0]        slv_en_o,
  output logic [N_SLV-1:0]        slv_lp_o,
  output logic                    rst_io_o,
  output logic [N_TMR-1:0]        tmr_busy_o,
  output logic [N_TMR*SLOT_W-1:0] tmr_slot_o
);
  tmr_cfg_t [N_TMR-1:0]           tmr_cfg;
  slv_cfg_t [N_SLV-1:0]           slv_cfg;
  logic [1:0]                     mode;
  logic                           pok_en;
  logic [N_SLV-1:0]               pok_mask;
  logic [1:0]                     hw_s;
  logic [N_TMR-1:0]               evt, up;
  logic [N_TMR-1:0][SLOT_W-1:0]   slot;

  fps_cfg #(.N_SLV(N_SLV), .ADDR_W(ADDR_W)) u_cfg (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .tmr_o(tmr_cfg), .slv_o(slv_cfg), .mode_o(mode),
    .pok_en_o(pok_en), .pok_mask_o(pok_mask)
  );

  fps_sync #(.W(2)) u_sync (.clk_i, .rst_ni, .d_i(hw_en_i), .q_o(hw_s));

  for (genvar k = 0; k < N_TMR; k++) begin : g_tmr
    fps_timer #(.BASE_US(BASE_US)) u_tmr (
      .clk_i, .rst_ni, .tick_i, .hw_i(hw_s), .cfg_i(tmr_cfg[k]),
      .evt_o(evt[k]), .up_o(up[k]), .busy_o(tmr_busy_o[k]), .slot_o(slot[k])
    );
  end

  assign tmr_slot_o = slot;

  for (genvar i = 0; i < N_SLV; i++) begin : g_slv
    fps_slave u_slv (
      .clk_i, .rst_ni, .evt_i(evt), .up_i(up), .slot_i(slot),
      .cfg_i(slv_cfg[i]), .mode_i(mode),
      .en_o(slv_en_o[i]), .lp_o(slv_lp_o[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_io_o <= 1'b1;
    else         rst_io_o <= !pok_en || (&(pok_i | ~pok_mask));
  end

  // R8
  pok_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pok_en && |(~pok_i & pok_mask)) |=> !rst_io_o);
  // R8
  pok_good_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pok_en || (pok_i & pok_mask) == pok_mask) |=> rst_io_o);
endmodule

// File: tb/fps_seq_tb.sv
module fps_seq_tb;
  localparam int N_SLV = 6;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic [1:0]       hw_en = '0;
  logic             wr_en = 1'b0;
  logic [3:0]       wr_addr = '0;
  logic [15:0]      wr_data = '0;
  logic [N_SLV-1:0] pok = '1;
  logic [N_SLV-1:0] en, lp;
  logic             rst_io;
  logic [2:0]       busy;
  logic [8:0]       slot;

  fps_seq u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(1'b1), .hw_en_i(hw_en),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data), .pok_i(pok),
    .slv_en_o(en), .slv_lp_o(lp), .rst_io_o(rst_io),
    .tmr_busy_o(busy), .tmr_slot_o(slot)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int errors = 0;

  // sel: 0 enables, 1 low-power, 2 busy, 3 rst_io, 4 timer0 slot
  typedef struct { int cyc; int sel; int val; string tag; } item_t;
  item_t q[$];
  item_t it;

  function automatic int actual(int sel);
    case (sel)
      0: return int'(en);
      1: return int'(lp);
      2: return int'(busy);
      3: return int'(rst_io);
      default: return int'(slot[2:0]);
    endcase
  endfunction

  task automatic cmp(int sel, int val, string tag);
    int a = actual(sel);
    checks++;
    if (a !== val) begin
      errors++;
      $display("FAIL %s sel%0d at cycle %0d: actual 0x%0h expected 0x%0h", tag, sel, cyc, a, val);
    end
  endtask

  task automatic expect_at(int c, int sel, int val, string tag);
    item_t e;
    e.cyc = c; e.sel = sel; e.val = val; e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: pops items as their cycle arrives
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      it = q.pop_front();
      cmp(it.sel, it.val, it.tag);
    end
  end

  task automatic wr(int addr, int data, output int w);
    @(negedge clk);
    w = cyc + 1;
    wr_en = 1'b1; wr_addr = 4'(addr); wr_data = 16'(data);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic hw(logic [1:0] v, output int h);
    @(negedge clk);
    h = cyc + 1;
    hw_en = v;
  endtask

  task automatic wait_to(int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog R3: actual hung expected done");
    finish_run();
  end

  initial begin
    int w, w2, h;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    cmp(0, 0, "R10 en");
    cmp(1, 0, "R10 lp");
    cmp(2, 0, "R10 busy");
    cmp(3, 1, "R10 rst_io");

    wr(1, 32'h04, w);   // timer1: hw0, code 1
    wr(2, 32'h01, w);   // timer2: hw1, code 0
    wr(3, 32'h01, w);   // sleep
    wr(4, 32'h0E0, w);  // s0 t0 up0 dn7
    wr(5, 32'h04C, w);  // s1 t0 up3 dn2
    wr(6, 32'h025, w);  // s2 t1 up1 dn1
    wr(7, 32'h003, w);  // s3 software, off
    wr(8, 32'h01E, w);  // s4 t2 up7 dn0
    wr(9, 32'h0B4, w);  // s5 t0 up5 dn5

    // rising sequence on software timer0
    wr(0, 32'h22, w);
    expect_at(w + 1, 0, 'h00, "R1 no enable before event");
    expect_at(w + 1, 2, 'h01, "R1 slot0 one clock after write");
    expect_at(w + 2, 0, 'h01, "R5 up slot0");
    expect_at(w + 40, 4, 0, "R3 slot0 held");
    expect_at(w + 41, 4, 1, "R3 slot1");
    expect_at(w + 121, 0, 'h01, "R5 before slot3");
    expect_at(w + 122, 0, 'h03, "R5 up slot3");
    expect_at(w + 201, 0, 'h03, "R5 before slot5");
    expect_at(w + 202, 0, 'h23, "R5 up slot5");
    expect_at(w + 320, 2, 'h01, "R3 busy last period");
    expect_at(w + 321, 2, 'h00, "R3 busy ends");
    wait_to(w + 330);

    // falling sequence, sleep
    wr(0, 32'h02, w);
    expect_at(w + 81, 0, 'h23, "R6 before dn2");
    expect_at(w + 82, 0, 'h21, "R6 sleep dn2");
    expect_at(w + 201, 0, 'h21, "R6 before dn5");
    expect_at(w + 202, 0, 'h01, "R6 sleep dn5");
    expect_at(w + 281, 0, 'h01, "R6 before dn7");
    expect_at(w + 282, 0, 'h00, "R6 sleep dn7");
    expect_at(w + 282, 1, 'h00, "R6 sleep no lp");
    wait_to(w + 330);

    // software slave
    wr(7, 32'h103, w);
    expect_at(w, 0, 'h00, "R7 not yet");
    expect_at(w + 1, 0, 'h08, "R7 follows bit");
    wait_to(w + 3);

    // hardware pin 0 into timer1, period code 1
    hw(2'b01, h);
    expect_at(h + 1, 2, 'h00, "R2 sync depth");
    expect_at(h + 2, 2, 'h02, "R2 event after sync");
    expect_at(h + 43, 0, 'h08, "R4 no slot1 at 40");
    expect_at(h + 82, 0, 'h08, "R4 before 80");
    expect_at(h + 83, 0, 'h0C, "R4 slot1 at 80");
    wait_to(h + 650);

    // low-power mode
    wr(3, 32'h02, w);
    hw(2'b00, h);
    expect_at(h + 82, 1, 'h00, "R6 lp before dn1");
    expect_at(h + 83, 1, 'h04, "R6 lp raised");
    expect_at(h + 83, 0, 'h0C, "R6 lp keeps enable");
    wait_to(h + 650);

    // mode none, hardware pin 1 into timer2
    wr(3, 32'h00, w);
    hw(2'b10, h);
    expect_at(h + 282, 0, 'h0C, "R1 hw1 before up7");
    expect_at(h + 283, 0, 'h1C, "R1 hw1 up7");
    wait_to(h + 330);
    hw(2'b00, h);
    expect_at(h + 3, 0, 'h1C, "R6 none keeps enable");
    expect_at(h + 3, 1, 'h04, "R6 none keeps lp");
    expect_at(h + 330, 0, 'h1C, "R6 none after sequence");
    wait_to(h + 335);

    // restart mid-sequence
    wr(3, 32'h01, w);
    wr(0, 32'h22, w);
    expect_at(w + 2, 0, 'h1D, "R9 slot0 up");
    expect_at(w + 41, 4, 1, "R9 slot1 reached");
    wait_to(w + 60);
    wr(0, 32'h02, w2);
    expect_at(w2 + 1, 4, 0, "R9 restart slot0");
    expect_at(w2 + 122, 0, 'h1D, "R9 old slot3 never fires");
    expect_at(w2 + 202, 0, 'h1D, "R9 old slot5 never fires");
    expect_at(w2 + 281, 0, 'h1D, "R9 before dn7");
    expect_at(w2 + 282, 0, 'h1C, "R9 dn7 after restart");
    expect_at(w2 + 320, 2, 'h01, "R9 busy from restart");
    expect_at(w2 + 321, 2, 'h00, "R9 busy ends");
    wait_to(w2 + 330);

    // power-good mapping, mask bits 0 and 2
    wr(3, 32'h0505, w);
    expect_at(w + 1, 3, 1, "R8 all good");
    wait_to(w + 3);
    @(negedge clk); pok[1] = 1'b0; h = cyc + 1;
    expect_at(h, 3, 1, "R8 unmasked drop ignored");
    wait_to(h + 2);
    @(negedge clk); pok[2] = 1'b0; h = cyc + 1;
    expect_at(h - 1, 3, 1, "R8 before drop");
    expect_at(h, 3, 0, "R8 masked drop");
    wait_to(h + 2);
    wr(3, 32'h0501, w);
    expect_at(w + 1, 3, 1, "R8 mapping off");
    wait_to(w + 3);
    wr(3, 32'h0505, w);
    expect_at(w + 1, 3, 0, "R8 mapping on again");
    wait_to(w + 2);
    @(negedge clk); pok[2] = 1'b1; h = cyc + 1;
    expect_at(h, 3, 1, "R8 recovered");
    wait_to(h + 2);

    wait (q.size() == 0);
    @(negedge clk);
    finish_run();
  end
endmodule